// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the control state machine that sits beside a delta-sigma decimator. It turns a start request into a run of decimator conversions. The request comes from a control-register bit or from a rising edge on an external start-of-conversion input. The block discards the conversions that only fill the decimator pipeline and captures the first valid result. It then raises a level end-of-conversion flag and holds the result until a processor register read or a DMA read takes it. The decimator datapath is outside the block. The block drives a one-cycle flush request to the decimator and counts the decimator's per-conversion valid strobes.

Four run modes are supported. One-shot mode produces one result per trigger and then waits. Repeated mode flushes and re-primes after every result, without further triggers. Fast repeated mode re-primes without the flush, which saves the flush cycle. Streaming mode primes once and then reports every conversion, re-priming only when the input channel changes. A sticky overrun flag records a result that replaced one nobody had read.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, `eoc`, `dec_restart` and every status bit are 0.
- R2: In idle, a trigger starts a run. A trigger is either a write to address 0 with bit 2 set, or a rising edge on `soc`. The mode is taken from write-data bits 1:0 if the write also carries the start bit, and from the last written value otherwise. The encodings are 0 one-shot, 1 repeated, 2 streaming and 3 fast repeated. `dec_restart` is high for exactly the one cycle that follows the trigger edge.
- R3: In one-shot mode, the block counts four `dec_valid` strobes after the flush and discards the data of the first three. It captures `dec_data` of the fourth as the result and then returns to idle (status bit 2, busy, reads 0).
- R4: `eoc` rises in the cycle after the capturing strobe. It stays high until a read of address 2 or a `dma_rd` pulse. A read of address 2 returns the held result.
- R5: Status bit 0 (done) mirrors `eoc`. It is cleared by the same access that clears `eoc`, and reading status (address 1) does not clear it.
- R6: A trigger of either kind that arrives while busy is ignored. It causes no flush and no extra result.
- R7: Status bit 1 (overrun) becomes set when a new result is captured while done is still set and no clearing read happens in that cycle. It stays set until a status read, which returns it as 1 and then clears it.
- R8: In streaming mode, every strobe after the four priming strobes produces a new result. A pulse on `mux_sw` causes a flush and a fresh set of four priming strobes.
- R9: In repeated mode, each result is followed by a one-cycle `dec_restart` and another four-strobe priming run, with no new trigger.
- R10: In fast repeated mode, each result is followed by another four-strobe priming run without `dec_restart`.
- R11: A write to address 0 with bit 3 set returns the block to idle from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 result |
| reg_wdata | input | 4 | Control write data: [1:0] mode, [2] start, [3] stop |
| reg_rdata | output | RES_W | Registered read data, valid the cycle after `reg_re` |
| soc | input | 1 | External start of conversion, rising edge triggers |
| eoc | output | 1 | End of conversion level, high while a result waits |
| res_data | output | RES_W | Held result, for DMA transfer |
| dma_rd | input | 1 | DMA has taken the result; clears `eoc` |
| mux_sw | input | 1 | Input channel changed; forces re-priming |
| dec_restart | output | 1 | One-cycle decimator flush request |
| dec_valid | input | 1 | Decimator finished one conversion |
| dec_data | input | RES_W | Decimator output word |

## Verification
A miscount in the priming counter shows up at the very first result. `eoc` rises one strobe early or late, and the captured word then belongs to a different strobe from the one the scoreboard expects. A wrong state after a capture appears within one cycle on `dec_restart` or in the busy bit: a one-shot run that stays busy, a repeated run that skips the flush, or a fast run that flushes anyway. Done and overrun bits that clear on the wrong access show up on the next status read. An `eoc` that drops without a read shows up when the result is read back.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MULTI  = 2'd1,
    MODE_CONT   = 2'd2,
    MODE_TURBO  = 2'd3
  } conv_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FLUSH  = 2'd1,
    ST_PRIME  = 2'd2,
    ST_STREAM = 2'd3
  } seq_state_t;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_RES  = 2'd2;

  localparam int CTL_W      = 4;
  localparam int BIT_START  = 2;
  localparam int BIT_STOP   = 3;
endpackage

// File: rtl/adcseq_edge.sv
module adcseq_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int PRIME_N = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig,
  input  logic       stop,
  input  conv_mode_t start_mode,
  input  logic       mux_sw,
  input  logic       dec_valid,
  output logic       dec_restart,
  output logic       busy,
  output logic       cap
);
  localparam int CW = (PRIME_N > 2) ? $clog2(PRIME_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRIME_N - 1);

  seq_state_t state;
  conv_mode_t mode_q;
  logic [CW-1:0] cnt;
  logic last_strobe;

  assign last_strobe = (cnt == LAST);
  assign cap = dec_valid & ((state == ST_PRIME && last_strobe && !mux_sw) ||
                            (state == ST_STREAM && !mux_sw));
  assign dec_restart = (state == ST_FLUSH);
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_q <= MODE_SINGLE;
      cnt    <= '0;
    end else if (stop) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trig) begin
            mode_q <= start_mode;
            state  <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          cnt   <= '0;
          state <= ST_PRIME;
        end
        ST_PRIME: begin
          if (mux_sw) begin
            state <= ST_FLUSH;
          end else if (dec_valid) begin
            if (last_strobe) begin
              cnt <= '0;
              case (mode_q)
                MODE_SINGLE: state <= ST_IDLE;
                MODE_MULTI:  state <= ST_FLUSH;
                MODE_TURBO:  state <= ST_PRIME;
                default:     state <= ST_STREAM;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (mux_sw) state <= ST_FLUSH;
        end
      endcase
    end
  end

  // R2
  restart_after_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && trig && !stop) |=> dec_restart);

  // R6
  busy_ignores_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRIME && trig && !stop && !mux_sw && !dec_valid) |=> (state == ST_PRIME && $stable(cnt)));

  // R3
  single_goes_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cap && mode_q == MODE_SINGLE && !stop) |=> !busy);

  // R10
  turbo_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (cap && mode_q == MODE_TURBO && !stop) |=> !dec_restart);

  // R9
  multi_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (cap && mode_q == MODE_MULTI && !stop) |=> dec_restart);
endmodule

// File: rtl/adcseq_hold.sv
module adcseq_hold #(
  parameter int RES_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [RES_W-1:0] data,
  input  logic             clr_done,
  input  logic             clr_ovr,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (cap) result <= data;
      if (cap)           done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (cap && done && !clr_done) ovr <= 1'b1;
      else if (clr_ovr)             ovr <= 1'b0;
    end
  end

  // R4
  eoc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !clr_done) |=> done);

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_done && !cap) |=> !done);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cap && done && !clr_done) |=> ovr);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adcseq_pkg::*;
#(
  parameter int RES_W   = 20,
  parameter int PRIME_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [1:0]       reg_addr,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [RES_W-1:0] reg_rdata,
  input  logic             soc,
  output logic             eoc,
  output logic [RES_W-1:0] res_data,
  input  logic             dma_rd,
  input  logic             mux_sw,
  output logic             dec_restart,
  input  logic             dec_valid,
  input  logic [RES_W-1:0] dec_data
);
  conv_mode_t mode_q, start_mode;
  logic ctl_wr, soc_rise, trig, stop;
  logic busy, cap, done, ovr, clr_done, clr_ovr;
  logic [RES_W-1:0] result;

  assign ctl_wr     = reg_we && (reg_addr == A_CTL);
  assign start_mode = (ctl_wr && reg_wdata[BIT_START]) ? conv_mode_t'(reg_wdata[1:0]) : mode_q;
  assign trig       = soc_rise | (ctl_wr & reg_wdata[BIT_START]);
  assign stop       = ctl_wr & reg_wdata[BIT_STOP];
  assign clr_done   = dma_rd | (reg_re && reg_addr == A_RES);
  assign clr_ovr    = reg_re && (reg_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_SINGLE;
    else if (ctl_wr) mode_q <= conv_mode_t'(reg_wdata[1:0]);
  end

  adcseq_edge u_edge (
    .clk (clk),
    .rst (rst),
    .din (soc),
    .rise(soc_rise)
  );

  adcseq_fsm #(.PRIME_N(PRIME_N)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .stop       (stop),
    .start_mode (start_mode),
    .mux_sw     (mux_sw),
    .dec_valid  (dec_valid),
    .dec_restart(dec_restart),
    .busy       (busy),
    .cap        (cap)
  );

  adcseq_hold #(.RES_W(RES_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .data    (dec_data),
    .clr_done(clr_done),
    .clr_ovr (clr_ovr),
    .result  (result),
    .done    (done),
    .ovr     (ovr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        A_CTL:   reg_rdata <= {{(RES_W-2){1'b0}}, mode_q};
        A_STAT:  reg_rdata <= {{(RES_W-3){1'b0}}, busy, ovr, done};
        A_RES:   reg_rdata <= result;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign eoc      = done;
  assign res_data = result;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!eoc && !dec_restart && !ovr));
endmodule

// File: tb/sim_adc_conv_ctrl.sv
module sim_adc_conv_ctrl;
  localparam int RW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 0, reg_re = 0, soc = 0, mux_sw = 0, dec_valid = 0;
  logic dma_rd = 1'b0;
  logic [1:0] reg_addr = 0;
  logic [3:0] reg_wdata = 0;
  logic [RW-1:0] dec_data = 0;
  logic [RW-1:0] reg_rdata, res_data;
  logic eoc, dec_restart;

  int errors = 0;
  int checks = 0;
  bit mon_en = 0;
  logic [RW-1:0] expq[$];

  always #2 clk = ~clk;

  adc_conv_ctrl #(.RES_W(RW), .PRIME_N(4)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .soc(soc), .eoc(eoc),
    .res_data(res_data), .dma_rd(dma_rd), .mux_sw(mux_sw),
    .dec_restart(dec_restart), .dec_valid(dec_valid), .dec_data(dec_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: consumes each result through the DMA path
  always @(negedge clk) begin
    if (mon_en && eoc && !dma_rd) begin
      if (expq.size() == 0) chk(0, "R4 unexpected result", int'(res_data), 0);
      else begin
        logic [RW-1:0] e;
        e = expq.pop_front();
        chk(res_data == e, "R3/R8 result", int'(res_data), int'(e));
      end
      dma_rd <= 1'b1;
    end else begin
      dma_rd <= 1'b0;
    end
  end

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk); reg_we = 1; reg_addr = 2'd0; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] v);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; v = reg_rdata;
  endtask

  task automatic soc_pulse();
    @(negedge clk); soc = 1;
    @(negedge clk); soc = 0;
  endtask

  task automatic send(input logic [RW-1:0] d, input bit expect_res, output logic rs);
    if (expect_res) expq.push_back(d);
    @(negedge clk); dec_valid = 1; dec_data = d;
    @(negedge clk); dec_valid = 0; rs = dec_restart;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    logic rs;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(eoc == 0, "R1 eoc", eoc, 0);
    chk(dec_restart == 0, "R1 restart", dec_restart, 0);
    rd(2'd1, v); chk(v == 0, "R1 status", v, 0);

    // R2/R3 one-shot via soc, scoreboard on
    mon_en = 1;
    wr_ctl(4'b0000);
    chk(dec_restart == 0, "R2 mode write alone", dec_restart, 0);
    soc_pulse();
    chk(dec_restart == 1, "R2 soc flush", dec_restart, 1);
    @(negedge clk);
    chk(dec_restart == 0, "R2 flush one cycle", dec_restart, 0);
    send(20'h11, 0, rs); send(20'h22, 0, rs); send(20'h33, 0, rs); send(20'h44, 1, rs);
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk(v[2] == 0, "R3 back to idle", v[2], 0);
    chk(expq.size() == 0, "R3 one result", expq.size(), 0);

    // R2/R6 start bit, triggers while busy ignored
    wr_ctl(4'b0100);
    chk(dec_restart == 1, "R2 start bit flush", dec_restart, 1);
    @(negedge clk);
    send(20'h101, 0, rs);
    soc_pulse();
    chk(dec_restart == 0, "R6 soc while busy", dec_restart, 0);
    wr_ctl(4'b0100);
    chk(dec_restart == 0, "R6 start while busy", dec_restart, 0);
    send(20'h102, 0, rs); send(20'h103, 0, rs); send(20'h104, 1, rs);
    send(20'h105, 0, rs);
    repeat (3) @(negedge clk);
    chk(eoc == 0, "R6 no extra result", eoc, 0);
    chk(expq.size() == 0, "R6 queue drained", expq.size(), 0);

    // R4/R5 eoc level held until result read
    mon_en = 0;
    soc_pulse(); @(negedge clk);
    send(20'h1, 0, rs); send(20'h2, 0, rs); send(20'h3, 0, rs); send(20'h5A5A5, 0, rs);
    repeat (10) @(negedge clk);
    chk(eoc == 1, "R4 eoc held", eoc, 1);
    rd(2'd1, v); chk(v == 20'h1, "R5 done set", v, 1);
    chk(eoc == 1, "R5 status read keeps eoc", eoc, 1);
    rd(2'd2, v); chk(v == 20'h5A5A5, "R4 result read", v, 20'h5A5A5);
    chk(eoc == 0, "R4 eoc cleared", eoc, 0);
    rd(2'd1, v); chk(v == 0, "R5 done cleared", v, 0);

    // R7/R8/R11 overrun in streaming mode
    wr_ctl(4'b0110); @(negedge clk);
    send(20'h10, 0, rs); send(20'h20, 0, rs); send(20'h30, 0, rs); send(20'h40, 0, rs);
    chk(eoc == 1, "R8 first stream result", eoc, 1);
    send(20'h77, 0, rs);
    rd(2'd1, v); chk(v == 20'h7, "R7 overrun set", v, 7);
    rd(2'd1, v); chk(v == 20'h5, "R7 overrun cleared", v, 5);
    rd(2'd2, v); chk(v == 20'h77, "R8 latest result", v, 20'h77);
    wr_ctl(4'b1000);
    rd(2'd1, v); chk(v == 0, "R11 stop to idle", v, 0);

    // R8 streaming scoreboard with channel change
    mon_en = 1;
    wr_ctl(4'b0110); @(negedge clk);
    send(20'hA0, 0, rs); send(20'hA1, 0, rs); send(20'hA2, 0, rs); send(20'hA3, 1, rs);
    send(20'hA4, 1, rs); send(20'hA5, 1, rs);
    @(negedge clk); mux_sw = 1;
    @(negedge clk); mux_sw = 0;
    chk(dec_restart == 1, "R8 channel change flush", dec_restart, 1);
    @(negedge clk);
    send(20'hB0, 0, rs); send(20'hB1, 0, rs); send(20'hB2, 0, rs); send(20'hB3, 1, rs);
    send(20'hB4, 1, rs);
    wr_ctl(4'b1000);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R8 all stream results", expq.size(), 0);

    // R9 repeated mode
    wr_ctl(4'b0101);
    chk(dec_restart == 1, "R9 start flush", dec_restart, 1);
    @(negedge clk);
    send(20'hC0, 0, rs); send(20'hC1, 0, rs); send(20'hC2, 0, rs); send(20'hC3, 1, rs);
    chk(rs == 1, "R9 auto flush", rs, 1);
    send(20'hC4, 0, rs); send(20'hC5, 0, rs); send(20'hC6, 0, rs); send(20'hC7, 1, rs);
    chk(rs == 1, "R9 second flush", rs, 1);
    wr_ctl(4'b1000);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R9 results", expq.size(), 0);

    // R10 fast repeated mode
    wr_ctl(4'b0111);
    chk(dec_restart == 1, "R10 start flush", dec_restart, 1);
    @(negedge clk);
    send(20'hD0, 0, rs); send(20'hD1, 0, rs); send(20'hD2, 0, rs); send(20'hD3, 1, rs);
    chk(rs == 0, "R10 no flush", rs, 0);
    send(20'hD4, 0, rs); send(20'hD5, 0, rs); send(20'hD6, 0, rs); send(20'hD7, 1, rs);
    chk(rs == 0, "R10 no flush again", rs, 0);
    wr_ctl(4'b1000);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R10 results", expq.size(), 0);
    rd(2'd1, v); chk(v[2] == 0, "R11 idle after stop", v[2], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule